// File: doc/BRIEF.md
# Multiply-Based Shift Unit

This block uses one W-by-W multiplier, keeping the low half of the product, to do three jobs. The first is plain multiplication. The second is a left shift, made by multiplying by a power of two. The third is a right shift, either logical or arithmetic.

A right shift reverses the bit order of the operand, multiplies it, and reverses the product back. For the arithmetic form, a negative operand is first inverted with an all-ones mask. The same mask is applied to the result afterwards, so vacated bits fill with the sign. A small companion converter turns a shift count n into the multiplicand 1 << n. Callers feed its output to the multiplicand input when they want a shift.

The result goes through one register stage when the output-register parameter is set, which is the default. The count converter is purely combinational.

Top module: `shmul_unit`

## Requirements
- R1: With op code 2'b00 (multiply), the result is the low W bits of a_i * m_i, and any higher product bits are dropped.
- R2: With op code 2'b01 (logical right), the result is the bit reverse of the low W bits of (bit reverse of a_i) * m_i. When m_i = 1 << n this equals a_i >> n.
- R3: With op code 2'b10 (arithmetic right), the result is rev(rev(a_i ^ s) * m_i) ^ s, where s is all ones when a_i[W-1] is 1 and all zeros otherwise. When m_i = 1 << n this equals the signed a_i >>> n, and the result MSB always equals a_i[W-1].
- R4: Multiply with m_i = 1 << n gives a_i << n for every n from 0 to W-1.
- R5: m_i = 0 gives 0 for multiply and logical right, and gives W copies of a_i[W-1] for arithmetic right.
- R6: The count converter drives pow2_o = 1 << amt_i when amt_i < W, and drives 0 when amt_i >= W. Its output never has more than one bit set.
- R7: Op code 2'b11 is reserved and yields a result of 0.
- R8: With REG_OUT = 1, res_o shows the result of the inputs sampled at a rising clock edge, just after that edge. An active-low asynchronous rst_n clears res_o to 0.
- R9: m_i = 1 returns a_i unchanged for multiply, logical right and arithmetic right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation: 00 multiply, 01 logical right, 10 arithmetic right, 11 reserved |
| a_i | input | W | Operand to shift or multiply |
| m_i | input | W | Multiplicand; a power of two for shifts |
| amt_i | input | $clog2(W)+1 | Shift count for the converter |
| pow2_o | output | W | 1 << amt_i, or 0 when the count is W or more |
| res_o | output | W | Result |

## Verification
The bench builds the unit with its defaults: W = 32 and REG_OUT = 1. These values put every count from 0 to 31 within reach, along with the out-of-range counts 32 to 63 on the 6-bit count input and the registered timing path. Every count is checked for all three operations against the language's native shift operators on random operands. Hand-computed vectors cover overflow, a zero multiplicand, the reserved code and the sign fill. Non-power multiplicands are checked against a loop-based bit reverse written in the bench.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

  typedef enum logic [1:0] {
    SHM_MUL = 2'b00,
    SHM_SHR = 2'b01,
    SHM_SAR = 2'b10,
    SHM_RSV = 2'b11
  } shm_op_e;

  // True when the operation runs through the reversed datapath
  function automatic logic op_is_right(input shm_op_e op);
    return (op == SHM_SHR) || (op == SHM_SAR);
  endfunction

  // True when the operation fills vacated bits with the sign
  function automatic logic op_is_signed(input shm_op_e op);
    return op == SHM_SAR;
  endfunction

endpackage

// File: rtl/shmul_rev.sv
module shmul_rev #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/shmul_pow2.sv
module shmul_pow2 #(
  parameter int W  = 32,
  parameter int SW = $clog2(W) + 1
) (
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  pow2
);
  localparam logic [SW-1:0] W_AMT = SW'(W);
  localparam logic [W-1:0]  ONE   = {{(W-1){1'b0}}, 1'b1};

  logic in_range;
  assign in_range = amt < W_AMT;
  assign pow2     = in_range ? (ONE << amt) : '0;
endmodule

// File: rtl/shmul_core.sv
module shmul_core
  import shmul_pkg::*;
#(
  parameter int W = 32
) (
  input  shm_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  output logic [W-1:0] res,
  output logic [W-1:0] sign_mask,
  output logic [W-1:0] prod_lo
);
  logic         is_right;
  logic [W-1:0] masked_a;
  logic [W-1:0] rev_in;
  logic [W-1:0] mul_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] right_res;

  assign is_right  = op_is_right(op);
  assign sign_mask = {W{op_is_signed(op) & a[W-1]}};
  assign masked_a  = a ^ sign_mask;

  shmul_rev #(.W(W)) u_rev_in (.din(masked_a), .dout(rev_in));

  assign mul_in  = is_right ? rev_in : a;
  // Only the low half of the product is kept
  assign prod_lo = mul_in * m;

  shmul_rev #(.W(W)) u_rev_out (.din(prod_lo), .dout(rev_out));

  assign right_res = rev_out ^ sign_mask;

  always_comb begin
    unique case (op)
      SHM_MUL: res = prod_lo;
      SHM_SHR,
      SHM_SAR: res = right_res;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/shmul_unit.sv
module shmul_unit
  import shmul_pkg::*;
#(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1,
  parameter int SW      = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  m_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  pow2_o,
  output logic [W-1:0]  res_o
);
  localparam logic [W-1:0] M_ONE = {{(W-1){1'b0}}, 1'b1};

  shm_op_e      op;
  logic [W-1:0] res_next;
  logic [W-1:0] sign_mask;
  logic [W-1:0] prod_lo;

  assign op = shm_op_e'(op_i);

  shmul_pow2 #(.W(W), .SW(SW)) u_pow2 (.amt(amt_i), .pow2(pow2_o));

  shmul_core #(.W(W)) u_core (
    .op       (op),
    .a        (a_i),
    .m        (m_i),
    .res      (res_next),
    .sign_mask(sign_mask),
    .prod_lo  (prod_lo)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_o <= '0;
      else        res_o <= res_next;
    end

    // R8
    reg_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> res_o == $past(res_next));
  end else begin : g_comb
    assign res_o = res_next;
  end

  // R3
  sar_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SHM_SAR) |-> res_next[W-1] == a_i[W-1]);

  // R2
  shr_clear_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SHM_SHR && !m_i[0]) |-> !res_next[W-1]);

  // R5
  zero_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_i == '0 && op != SHM_RSV) |-> res_next == sign_mask);

  // R9
  unit_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_i == M_ONE && op != SHM_RSV) |-> res_next == a_i);

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SHM_RSV) |-> res_next == '0);

  // R6
  pow2_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pow2_o));

  // R6
  pow2_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amt_i >= SW'(W)) |-> pow2_o == '0);

  // R1
  mul_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SHM_MUL) |-> res_next == prod_lo);
endmodule

// File: tb/sim_shmul_unit.sv
`timescale 1ns/1ps
module sim_shmul_unit;
  localparam int W  = 32;
  localparam int SW = 6;
  localparam int NV = 13;

  // Vector table: op, a, m, expected, requirement number
  localparam logic [1:0]  T_OP [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
                                        2'd1, 2'd1, 2'd1,
                                        2'd2, 2'd2, 2'd2, 2'd2,
                                        2'd3};
  localparam logic [31:0] T_A  [NV] = '{32'h0000_0003, 32'hFFFF_FFFF, 32'h8000_0001,
                                        32'h0001_0000, 32'h0000_1234,
                                        32'h0000_0040, 32'h8000_0000, 32'hDEAD_BEEF,
                                        32'h8000_0000, 32'hFFFF_FFF0, 32'h7FFF_FFFF,
                                        32'h8000_0000, 32'h0000_1234};
  localparam logic [31:0] T_M  [NV] = '{32'h8, 32'h2, 32'h4, 32'h0001_0000, 32'h1,
                                        32'h8, 32'h8000_0000, 32'h0,
                                        32'h8, 32'h10, 32'h4000_0000, 32'h0,
                                        32'h5};
  localparam logic [31:0] T_E  [NV] = '{32'h18, 32'hFFFF_FFFE, 32'h4, 32'h0, 32'h1234,
                                        32'h8, 32'h1, 32'h0,
                                        32'hF000_0000, 32'hFFFF_FFFF, 32'h1, 32'hFFFF_FFFF,
                                        32'h0};
  // R4 R1 R1 R1 R9 / R2 R2 R5 / R3 R3 R3 R5 / R7
  localparam int          T_R  [NV] = '{4, 1, 1, 1, 9, 2, 2, 5, 3, 3, 3, 5, 7};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    op_i = 2'd0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  m_i = '0;
  logic [SW-1:0] amt_i = '0;
  logic [W-1:0]  pow2_o;
  logic [W-1:0]  res_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shmul_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .m_i(m_i),
    .amt_i(amt_i), .pow2_o(pow2_o), .res_o(res_o)
  );

  function automatic logic [31:0] flip(input logic [31:0] v);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [31:0] a, input logic [31:0] m,
                     output logic [31:0] r);
    @(negedge clk);
    op_i = op; a_i = a; m_i = m;
    @(posedge clk);
    #1;
    r = res_o;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] a;
    logic [31:0] m;
    // R8: reset state
    #7;
    check("R8 reset", res_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      run(T_OP[k], T_A[k], T_M[k], r);
      check($sformatf("R%0d vector %0d", T_R[k], k), r, T_E[k]);
    end

    for (int n = 0; n < 32; n++) begin
      a = $urandom;
      m = 32'h1 << n;
      run(2'd0, a, m, r);
      check($sformatf("R4 shl n=%0d", n), r, a << n);
      run(2'd1, a, m, r);
      check($sformatf("R2 shr n=%0d", n), r, a >> n);
      run(2'd2, a, m, r);
      check($sformatf("R3 sar n=%0d", n), r, 32'($signed(a) >>> n));
      run(2'd2, a | 32'h8000_0000, m, r);
      check($sformatf("R3 sar neg n=%0d", n), r, 32'($signed(a | 32'h8000_0000) >>> n));
      amt_i = SW'(n);
      #1;
      check($sformatf("R6 pow2 n=%0d", n), pow2_o, 32'h1 << n);
    end

    for (int n = 32; n < 64; n++) begin
      amt_i = SW'(n);
      #1;
      check($sformatf("R6 pow2 out of range n=%0d", n), pow2_o, 32'h0);
    end

    for (int k = 0; k < 20; k++) begin
      a = $urandom;
      m = $urandom;
      run(2'd0, a, m, r);
      check("R1 random multiply", r, a * m);
      run(2'd1, a, m, r);
      check("R2 random reversed multiply", r, flip(flip(a) * m));
      run(2'd2, a, m, r);
      check("R3 random signed reversed",
            r, flip(flip(a ^ {32{a[31]}}) * m) ^ {32{a[31]}});
    end

    // R8: result held until next edge, then cleared by reset
    @(negedge clk);
    op_i = 2'd0; a_i = 32'h5; m_i = 32'h3;
    #0.5;
    check("R8 before edge", res_o, r);
    @(posedge clk);
    #1;
    check("R8 after edge", res_o, 32'hF);
    rst_n = 1'b0;
    #1;
    check("R8 async reset", res_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule